// File: doc/BRIEF.md
# Dual-CPU Paged Memory Mapper

This block sits between two 8-bit processors and a shared 256 KB physical RAM. Each processor sees a 64 KB logical space cut into 32 pages of 2 KB. A shared table of 32 maps, each holding 32 page entries, turns a logical page into a physical 2 KB frame. Each processor has its own map-info register. Its low five bits pick the map, and its three upper flags open fixed holes in the paged space for video RAM, a card-register window and a peripheral window. The flags also turn on a parity-error mode that raises an interrupt on some reads.

A separate 16 KB overlay window can cover one quarter of the logical space and takes precedence over paging. A mask flag hides the overlay from the second processor only. Map entries are loaded in two steps: a control byte goes into a latch, then a data write stores the entry.

Each access is resolved in the cycle after its request. The block reports the target as a one-hot region select and a target address, and forwards writes. It returns the external target's read data, or 0x00 when nothing answers.

Top module: `dual_page_mapper`

## Requirements
- R1: A paged access uses map entry index {mapinfo[4:0], addr[15:11]}. If the entry's bit 7 is set, the next cycle shows region select bit 0 and target address {entry[6:0], addr[10:0]}.
- R2: A paged access whose entry has bit 7 clear gives an all-zero region select. A read returns 0x00 and a write is not forwarded (tgt_we low).
- R3: With mapinfo bit 5 clear, addresses 0x8000-0xBFFF select region bit 1 (video) with target address addr[13:0]. With bit 5 set, that range is paged.
- R4: With mapinfo bit 7 clear, 0xE000-0xE03F selects region bit 2 (card registers) with target address addr[5:0]. The rest of 0xE000-0xEFFF is paged.
- R5: With mapinfo bit 7 clear, 0xF000-0xFFFF selects region bit 3 (peripherals) with target address addr[11:0]. With bit 7 set, it is paged.
- R6: The overlay control field is {mask[3], on[2], base[1:0]}. The overlay is live when on=1 and base is non-zero. An address with addr[15:14]==base then selects region bit 4 with target address addr[13:0]. The overlay overrides paging, but the video, card and peripheral holes take precedence over it.
- R7: When mask=1, the overlay is hidden from processor 1, whose access falls through to paging. Processor 0 is unaffected.
- R8: With mapinfo bit 6 set, a read in 0x0000-0x7FFF or 0xC000-0xDFFF that resolves to paging pulses perr_irq in its response cycle, even if the page is absent. Writes, overlay hits and other ranges give no pulse.
- R9: A loader write to an even offset latches ld_data. A write to an odd offset o stores {en, ld_data[6:0]} at entry o>>1. Here en = latch bit 7 AND latch[2:0]==CARD_ID (default 0).
- R10: After reset, both map-info registers and the overlay control are zero. The video, card and peripheral holes are therefore open and the overlay is off.
- R11: A cycle with no request gives an all-zero region select, no perr_irq and no write in the next cycle. A region select never has more than one bit set.
- R12: The two processors resolve in the same cycle, each through its own map-info register.
- R13: In the response cycle, cpu_rdata equals tgt_rdata whenever a region is selected. A forwarded write presents the request's data on tgt_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Map loader write strobe |
| ld_off | input | 11 | Loader offset; bit 0 selects latch (0) or entry (1) |
| ld_data | input | 8 | Loader data |
| mi_we | input | 2 | Per-processor map-info write strobe |
| mi_wdata | input | 2x8 | Per-processor map-info value |
| ovl_we | input | 1 | Overlay control write strobe |
| ovl_wdata | input | 4 | Overlay control {mask, on, base[1:0]} |
| cpu_req | input | 2 | Access request per processor |
| cpu_we | input | 2 | Write flag per processor |
| cpu_addr | input | 2x16 | Logical address per processor |
| cpu_wdata | input | 2x8 | Write data per processor |
| cpu_rdata | output | 2x8 | Read data, one cycle after the request |
| rsp_sel | output | 2x5 | One-hot region: 0 paged, 1 video, 2 card, 3 peripheral, 4 overlay |
| tgt_addr | output | 2x18 | Physical or window-relative target address |
| tgt_we | output | 2 | Forwarded write strobe |
| tgt_wdata | output | 2x8 | Forwarded write data |
| tgt_rdata | input | 2x8 | Data returned by the selected target |
| perr_irq | output | 2 | Parity-error interrupt pulse |

## Verification
The bench goes after the precedence edges. Addresses 0xE03F and 0xE040 straddle the card window. The top quarter has an overlay base that overlaps the peripheral hole, and video with overlay base 2 catches a design that lets the overlay steal a fixed hole or lose to paging. Reloaded entries, an entry written while the latch names another card, and the absent page catch a loader that ignores the card match or forwards writes to missing frames. Parity reads on absent pages, writes and overlay hits expose an interrupt tied to the wrong condition. Running the two processors on different maps and masks catches crossed map-info registers or an overlay mask applied to both.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int NCPU     = 2;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int OFF_W    = 11;
  localparam int PAGE_W   = ADDR_W - OFF_W;
  localparam int MAPSEL_W = 5;
  localparam int FRAME_W  = DATA_W - 1;
  localparam int PHYS_W   = FRAME_W + OFF_W;
  localparam int IDX_W    = MAPSEL_W + PAGE_W;
  localparam int NENTRY   = 1 << IDX_W;
  localparam int WIN_W    = 14;
  localparam int NREG     = 5;
  localparam int CARD_W   = 3;
  localparam int CARD_SPAN_W = 6;
  localparam int PERI_W   = 12;

  // region select bit positions
  localparam int RG_PAGED  = 0;
  localparam int RG_VIDEO  = 1;
  localparam int RG_CARD   = 2;
  localparam int RG_PERIPH = 3;
  localparam int RG_OVL    = 4;

  // map-info upper flags (mapinfo[7:5])
  localparam int MF_W      = 3;
  localparam int MF_VIDOFF = 0;
  localparam int MF_PERR   = 1;
  localparam int MF_IOOFF  = 2;

  // overlay control field
  localparam int OV_W    = 4;
  localparam int OV_MASK = 3;
  localparam int OV_ON   = 2;
  localparam int OV_BASE_W = 2;
  localparam int OVL_MASKED_CPU = 1;

  // address tags
  localparam logic [1:0] VID_TAG  = 2'b10;
  localparam logic [3:0] CARD_TAG = 4'hE;
  localparam logic [3:0] PERI_TAG = 4'hF;
  localparam logic [2:0] PERR_HI_TAG = 3'b110;

  typedef enum logic [2:0] {
    CL_PAGED, CL_VIDEO, CL_CARD, CL_PERIPH, CL_OVL
  } win_cls_e;

  typedef struct packed {
    win_cls_e          cls;
    logic              perr;
    logic [PHYS_W-1:0] waddr;
  } win_dec_t;
endpackage

// File: rtl/dpm_map_loader.sv
module dpm_map_loader
  import dpm_pkg::*;
#(
  parameter int CARD_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic [IDX_W:0]    ld_off,
  input  logic [DATA_W-1:0] ld_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_entry
);
  localparam int LATCH_W = CARD_W + 1;

  logic [LATCH_W-1:0] latch_q, latch_d;
  logic               card_hit;

  always_comb begin
    latch_d = latch_q;
    if (ld_we && !ld_off[0])
      latch_d = {ld_data[DATA_W-1], ld_data[CARD_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  assign card_hit = latch_q[LATCH_W-1] &&
                    (latch_q[CARD_W-1:0] == CARD_W'(CARD_ID));
  assign wr_en    = ld_we && ld_off[0];
  assign wr_idx   = ld_off[IDX_W:1];
  assign wr_entry = {card_hit, ld_data[FRAME_W-1:0]};
endmodule

// File: rtl/dpm_map_store.sv
module dpm_map_store
  import dpm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]             wr_entry,
  input  logic [NCPU-1:0]               rd_en,
  input  logic [NCPU-1:0][IDX_W-1:0]    rd_idx,
  output logic [NCPU-1:0][DATA_W-1:0]   rd_entry
);
  logic [DATA_W-1:0] mem [NENTRY];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_entry;
  end

  for (genvar g = 0; g < NCPU; g++) begin : g_rd
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (rd_en[g]) q <= mem[rd_idx[g]];
    end
    assign rd_entry[g] = q;
  end
endmodule

// File: rtl/dpm_win_decode.sv
module dpm_win_decode
  import dpm_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr,
  input  logic [MF_W-1:0]      mflag,
  input  logic                 ovl_en,
  input  logic [OV_BASE_W-1:0] ovl_base,
  output win_dec_t             dec
);
  logic in_vid, in_card, in_peri, in_ovl, in_perr;

  always_comb begin
    in_vid  = (addr[ADDR_W-1 -: 2] == VID_TAG) && !mflag[MF_VIDOFF];
    in_card = (addr[ADDR_W-1 -: 4] == CARD_TAG) &&
              (addr[PERI_W-1:CARD_SPAN_W] == '0) && !mflag[MF_IOOFF];
    in_peri = (addr[ADDR_W-1 -: 4] == PERI_TAG) && !mflag[MF_IOOFF];
    in_ovl  = ovl_en && (addr[ADDR_W-1 -: OV_BASE_W] == ovl_base);
    in_perr = mflag[MF_PERR] &&
              (!addr[ADDR_W-1] || (addr[ADDR_W-1 -: 3] == PERR_HI_TAG));

    dec.cls   = CL_PAGED;
    dec.perr  = 1'b0;
    dec.waddr = {{(PHYS_W-OFF_W){1'b0}}, addr[OFF_W-1:0]};
    if (in_vid) begin
      dec.cls   = CL_VIDEO;
      dec.waddr = {{(PHYS_W-WIN_W){1'b0}}, addr[WIN_W-1:0]};
    end else if (in_card) begin
      dec.cls   = CL_CARD;
      dec.waddr = {{(PHYS_W-CARD_SPAN_W){1'b0}}, addr[CARD_SPAN_W-1:0]};
    end else if (in_peri) begin
      dec.cls   = CL_PERIPH;
      dec.waddr = {{(PHYS_W-PERI_W){1'b0}}, addr[PERI_W-1:0]};
    end else if (in_ovl) begin
      dec.cls   = CL_OVL;
      dec.waddr = {{(PHYS_W-WIN_W){1'b0}}, addr[WIN_W-1:0]};
    end else begin
      dec.perr  = in_perr;
    end
  end
endmodule

// File: rtl/dpm_resp_stage.sv
module dpm_resp_stage
  import dpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  win_dec_t          dec,
  input  logic [DATA_W-1:0] entry,
  input  logic [DATA_W-1:0] tgt_rdata,
  output logic [NREG-1:0]   sel,
  output logic [PHYS_W-1:0] taddr,
  output logic              tgt_we,
  output logic [DATA_W-1:0] tgt_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              perr
);
  logic              v_q, v_d;
  logic              we_q, we_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  win_dec_t          dec_q, dec_d;

  always_comb begin
    v_d   = req;
    we_d  = we_q;
    wd_d  = wd_q;
    dec_d = dec_q;
    if (req) begin
      we_d  = we;
      wd_d  = wdata;
      dec_d = dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      we_q  <= 1'b0;
      wd_q  <= '0;
      dec_q <= '0;
    end else begin
      v_q   <= v_d;
      we_q  <= we_d;
      wd_q  <= wd_d;
      dec_q <= dec_d;
    end
  end

  always_comb begin
    sel   = '0;
    taddr = dec_q.waddr;
    perr  = 1'b0;
    if (v_q) begin
      unique case (dec_q.cls)
        CL_PAGED: begin
          perr = dec_q.perr && !we_q;
          if (entry[DATA_W-1]) begin
            sel[RG_PAGED] = 1'b1;
            taddr = {entry[FRAME_W-1:0], dec_q.waddr[OFF_W-1:0]};
          end
        end
        CL_VIDEO:  sel[RG_VIDEO]  = 1'b1;
        CL_CARD:   sel[RG_CARD]   = 1'b1;
        CL_PERIPH: sel[RG_PERIPH] = 1'b1;
        CL_OVL:    sel[RG_OVL]    = 1'b1;
        default:   sel = '0;
      endcase
    end
  end

  assign tgt_we    = we_q && (sel != '0);
  assign tgt_wdata = wd_q;
  assign rdata     = (sel != '0) ? tgt_rdata : '0;
endmodule

// File: rtl/dual_page_mapper.sv
module dual_page_mapper
  import dpm_pkg::*;
#(
  parameter int CARD_ID = 0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ld_we,
  input  logic [IDX_W:0]                 ld_off,
  input  logic [DATA_W-1:0]              ld_data,
  input  logic [NCPU-1:0]                mi_we,
  input  logic [NCPU-1:0][DATA_W-1:0]    mi_wdata,
  input  logic                           ovl_we,
  input  logic [OV_W-1:0]                ovl_wdata,
  input  logic [NCPU-1:0]                cpu_req,
  input  logic [NCPU-1:0]                cpu_we,
  input  logic [NCPU-1:0][ADDR_W-1:0]    cpu_addr,
  input  logic [NCPU-1:0][DATA_W-1:0]    cpu_wdata,
  output logic [NCPU-1:0][DATA_W-1:0]    cpu_rdata,
  output logic [NCPU-1:0][NREG-1:0]      rsp_sel,
  output logic [NCPU-1:0][PHYS_W-1:0]    tgt_addr,
  output logic [NCPU-1:0]                tgt_we,
  output logic [NCPU-1:0][DATA_W-1:0]    tgt_wdata,
  input  logic [NCPU-1:0][DATA_W-1:0]    tgt_rdata,
  output logic [NCPU-1:0]                perr_irq
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_n_sync <= rst_meta;
    end
  end

  logic [NCPU-1:0][DATA_W-1:0] mi_q, mi_d;
  logic [OV_W-1:0]             ovl_q, ovl_d;
  logic [NCPU-1:0][MF_W-1:0]   mi_flag;

  always_comb begin
    mi_d  = mi_q;
    ovl_d = ovl_q;
    for (int i = 0; i < NCPU; i++)
      if (mi_we[i]) mi_d[i] = mi_wdata[i];
    if (ovl_we) ovl_d = ovl_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      mi_q  <= '0;
      ovl_q <= '0;
    end else begin
      mi_q  <= mi_d;
      ovl_q <= ovl_d;
    end
  end

  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_entry;

  dpm_map_loader #(.CARD_ID(CARD_ID)) u_loader (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .ld_we    (ld_we),
    .ld_off   (ld_off),
    .ld_data  (ld_data),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_entry (wr_entry)
  );

  logic [NCPU-1:0][IDX_W-1:0]  rd_idx;
  logic [NCPU-1:0][DATA_W-1:0] rd_entry;

  dpm_map_store u_store (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_entry (wr_entry),
    .rd_en    (cpu_req),
    .rd_idx   (rd_idx),
    .rd_entry (rd_entry)
  );

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    logic     ovl_en;
    win_dec_t dec;

    assign mi_flag[g] = mi_q[g][DATA_W-1 -: MF_W];
    assign rd_idx[g]  = {mi_q[g][MAPSEL_W-1:0], cpu_addr[g][ADDR_W-1 -: PAGE_W]};
    assign ovl_en     = ovl_q[OV_ON] && (ovl_q[OV_BASE_W-1:0] != '0) &&
                        !((g == OVL_MASKED_CPU) && ovl_q[OV_MASK]);

    dpm_win_decode u_dec (
      .addr     (cpu_addr[g]),
      .mflag    (mi_flag[g]),
      .ovl_en   (ovl_en),
      .ovl_base (ovl_q[OV_BASE_W-1:0]),
      .dec      (dec)
    );

    dpm_resp_stage u_rsp (
      .clk       (clk),
      .rst_n     (rst_n_sync),
      .req       (cpu_req[g]),
      .we        (cpu_we[g]),
      .wdata     (cpu_wdata[g]),
      .dec       (dec),
      .entry     (rd_entry[g]),
      .tgt_rdata (tgt_rdata[g]),
      .sel       (rsp_sel[g]),
      .taddr     (tgt_addr[g]),
      .tgt_we    (tgt_we[g]),
      .tgt_wdata (tgt_wdata[g]),
      .rdata     (cpu_rdata[g]),
      .perr      (perr_irq[g])
    );
  end
endmodule

// File: rtl/dpm_checker.sv
module dpm_checker
  import dpm_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCPU-1:0]           cpu_req,
  input logic [NCPU-1:0]           cpu_we,
  input logic [NCPU-1:0][MF_W-1:0] mi_flag,
  input logic [OV_W-1:0]           ovl_q,
  input logic [NCPU-1:0][NREG-1:0] rsp_sel,
  input logic [NCPU-1:0]           tgt_we,
  input logic [NCPU-1:0]           perr_irq
);
  for (genvar g = 0; g < NCPU; g++) begin : g_chk
    assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_sel[g]));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req[g] |=> (rsp_sel[g] == '0) && !tgt_we[g] && !perr_irq[g]);

    assert_write_origin_R13: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_we[g] |-> $past(cpu_req[g] && cpu_we[g]));

    assert_perr_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      perr_irq[g] |-> $past(cpu_req[g] && !cpu_we[g] && mi_flag[g][MF_PERR]));

    assert_video_hole_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_sel[g][RG_VIDEO] |-> !$past(mi_flag[g][MF_VIDOFF]));

    assert_io_hole_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_sel[g][RG_CARD] || rsp_sel[g][RG_PERIPH]) |-> !$past(mi_flag[g][MF_IOOFF]));

    assert_ovl_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_sel[g][RG_OVL] |-> $past(ovl_q[OV_ON] && (ovl_q[OV_BASE_W-1:0] != '0)));
  end

  assert_ovl_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_sel[OVL_MASKED_CPU][RG_OVL] |-> !$past(ovl_q[OV_MASK]));
endmodule

bind dual_page_mapper dpm_checker u_dpm_checker (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .cpu_req  (cpu_req),
  .cpu_we   (cpu_we),
  .mi_flag  (mi_flag),
  .ovl_q    (ovl_q),
  .rsp_sel  (rsp_sel),
  .tgt_we   (tgt_we),
  .perr_irq (perr_irq)
);

// File: tb/dual_page_mapper_bench.sv
module dual_page_mapper_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              ld_we;
  logic [10:0]       ld_off;
  logic [7:0]        ld_data;
  logic [1:0]        mi_we;
  logic [1:0][7:0]   mi_wdata;
  logic              ovl_we;
  logic [3:0]        ovl_wdata;
  logic [1:0]        cpu_req, cpu_we;
  logic [1:0][15:0]  cpu_addr;
  logic [1:0][7:0]   cpu_wdata, cpu_rdata, tgt_wdata, tgt_rdata;
  logic [1:0][4:0]   rsp_sel;
  logic [1:0][17:0]  tgt_addr;
  logic [1:0]        tgt_we, perr_irq;

  localparam logic [7:0] TRD0 = 8'h5A;
  localparam logic [7:0] TRD1 = 8'hC3;
  assign tgt_rdata[0] = TRD0;
  assign tgt_rdata[1] = TRD1;

  dual_page_mapper u_dual_page_mapper (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_off(ld_off), .ld_data(ld_data),
    .mi_we(mi_we), .mi_wdata(mi_wdata), .ovl_we(ovl_we), .ovl_wdata(ovl_wdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .rsp_sel(rsp_sel), .tgt_addr(tgt_addr), .tgt_we(tgt_we),
    .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata), .perr_irq(perr_irq)
  );

  // bench-side model state
  logic [7:0] bmap [1024];
  logic [7:0] bmi  [2];
  logic [3:0] bovl;

  typedef struct {
    int         cyc;
    int         cpu;
    logic [4:0] sel;
    logic [17:0] ta;
    logic       twe;
    logic [7:0] twd;
    logic       irq;
    logic [7:0] rd;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int cyc = 0;
  int vectors = 0;
  int miscomp = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic exp_t model(int cpu, logic rq, logic w, logic [15:0] a,
                                 logic [7:0] d, string tag);
    exp_t e;
    logic [7:0] mi, ent;
    logic ovl_on;
    e.cyc = cyc + 1; e.cpu = cpu; e.tag = tag;
    e.sel = '0; e.ta = '0; e.twe = 0; e.twd = d; e.irq = 0; e.rd = '0;
    if (!rq) return e;
    mi = bmi[cpu];
    ovl_on = bovl[2] && (bovl[1:0] != 0) && !(cpu == 1 && bovl[3]);
    if (a[15:14] == 2'b10 && !mi[5]) begin
      e.sel = 5'b00010; e.ta = {4'b0, a[13:0]};
    end else if (a >= 16'hE000 && a <= 16'hE03F && !mi[7]) begin
      e.sel = 5'b00100; e.ta = {12'b0, a[5:0]};
    end else if (a[15:12] == 4'hF && !mi[7]) begin
      e.sel = 5'b01000; e.ta = {6'b0, a[11:0]};
    end else if (ovl_on && a[15:14] == bovl[1:0]) begin
      e.sel = 5'b10000; e.ta = {4'b0, a[13:0]};
    end else begin
      ent = bmap[{mi[4:0], a[15:11]}];
      e.irq = !w && mi[6] && (!a[15] || a[15:13] == 3'b110);
      if (ent[7]) begin
        e.sel = 5'b00001; e.ta = {ent[6:0], a[10:0]};
      end
    end
    e.twe = w && (e.sel != 0);
    e.rd  = (e.sel != 0) ? (cpu == 0 ? TRD0 : TRD1) : 8'h00;
    return e;
  endfunction

  task automatic check_item(exp_t e);
    bit bad = 0;
    int c = e.cpu;
    vectors++;
    if (rsp_sel[c] !== e.sel) begin
      $display("FAIL %s cpu%0d rsp_sel act=%b exp=%b", e.tag, c, rsp_sel[c], e.sel); bad = 1;
    end
    if (e.sel != 0 && tgt_addr[c] !== e.ta) begin
      $display("FAIL %s cpu%0d tgt_addr act=%h exp=%h", e.tag, c, tgt_addr[c], e.ta); bad = 1;
    end
    if (tgt_we[c] !== e.twe) begin
      $display("FAIL %s cpu%0d tgt_we act=%b exp=%b", e.tag, c, tgt_we[c], e.twe); bad = 1;
    end
    if (e.twe && tgt_wdata[c] !== e.twd) begin
      $display("FAIL %s cpu%0d tgt_wdata act=%h exp=%h", e.tag, c, tgt_wdata[c], e.twd); bad = 1;
    end
    if (perr_irq[c] !== e.irq) begin
      $display("FAIL %s cpu%0d perr_irq act=%b exp=%b", e.tag, c, perr_irq[c], e.irq); bad = 1;
    end
    if (cpu_rdata[c] !== e.rd) begin
      $display("FAIL %s cpu%0d cpu_rdata act=%h exp=%h", e.tag, c, cpu_rdata[c], e.rd); bad = 1;
    end
    if (bad) miscomp++;
  endtask

  // monitor: compare results due in this cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].cyc == cyc) check_item(exp_q.pop_front());
  end

  task automatic idle_inputs();
    ld_we = 0; ld_off = '0; ld_data = '0;
    mi_we = '0; mi_wdata = '0; ovl_we = 0; ovl_wdata = '0;
    cpu_req = '0; cpu_we = '0; cpu_addr = '0; cpu_wdata = '0;
  endtask

  task automatic step(input logic r0, input logic w0, input logic [15:0] a0, input logic [7:0] d0,
                      input logic r1, input logic w1, input logic [15:0] a1, input logic [7:0] d1,
                      input string tag);
    @(negedge clk);
    idle_inputs();
    cpu_req = {r1, r0}; cpu_we = {w1, w0};
    cpu_addr[0] = a0; cpu_addr[1] = a1;
    cpu_wdata[0] = d0; cpu_wdata[1] = d1;
    exp_q.push_back(model(0, r0, w0, a0, d0, tag));
    exp_q.push_back(model(1, r1, w1, a1, d1, tag));
  endtask

  task automatic acc0(input logic w, input logic [15:0] a, input logic [7:0] d, input string tag);
    step(1'b1, w, a, d, 1'b0, 1'b0, 16'h0, 8'h0, tag);
  endtask

  task automatic load_raw(input logic [7:0] latch, input logic [9:0] idx, input logic [7:0] data);
    @(negedge clk);
    idle_inputs();
    ld_we = 1; ld_off = {idx, 1'b0}; ld_data = latch;
    @(negedge clk);
    ld_off = {idx, 1'b1}; ld_data = data;
    bmap[idx] = {(latch[7] && latch[2:0] == 3'd0), data[6:0]};
  endtask

  task automatic set_mi(input int c, input logic [7:0] v);
    @(negedge clk);
    idle_inputs();
    mi_we[c] = 1'b1; mi_wdata[c] = v; bmi[c] = v;
  endtask

  task automatic set_ovl(input logic [3:0] v);
    @(negedge clk);
    idle_inputs();
    ovl_we = 1; ovl_wdata = v; bovl = v;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      $display("FAIL R11 watchdog act=timeout exp=completion");
      miscomp++;
      summary();
      $finish;
    end
  end

  initial begin
    idle_inputs();
    bmi[0] = 8'h00; bmi[1] = 8'h00; bovl = 4'h0;
    for (int i = 0; i < 1024; i++) bmap[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state of the outputs
    vectors++;
    if (rsp_sel !== '0 || perr_irq !== '0 || tgt_we !== '0 || cpu_rdata !== '0) begin
      $display("FAIL R10 reset outputs act=%h/%b/%b exp=0", rsp_sel, perr_irq, tgt_we);
      miscomp++;
    end

    // R9: clear maps 0, 2, 5 then load them
    for (int p = 0; p < 32; p++) begin
      load_raw((p == 3) ? 8'h00 : 8'h80, {5'd0, 5'(p)}, 8'(8'h10 + p));
      load_raw(8'h80, {5'd2, 5'(p)}, 8'(8'h60 + p));
      load_raw((p == 7) ? 8'h81 : 8'h80, {5'd5, 5'(p)}, 8'(8'hC0 + p));
    end

    // R10 defaults: holes open, paging map 0
    acc0(0, 16'h9ABC, 8'h00, "R10");
    acc0(0, 16'hE010, 8'h00, "R10");
    acc0(0, 16'hF123, 8'h00, "R10");
    // R1 paged, R12 both processors together
    step(1, 0, 16'h1234, 8'h00, 1, 0, 16'h1234, 8'h00, "R1");
    set_mi(1, 8'h22);
    step(1, 0, 16'h1234, 8'h00, 1, 0, 16'h1234, 8'h00, "R12");
    // R3 video hole vs paged
    step(1, 0, 16'h9ABC, 8'h00, 1, 0, 16'h9ABC, 8'h00, "R3");
    step(1, 1, 16'hBFFF, 8'h31, 1, 1, 16'hBFFF, 8'h32, "R3");
    // R2 absent page
    acc0(0, 16'h1A00, 8'h00, "R2");
    acc0(1, 16'h1BFF, 8'h99, "R2");
    // R13 write forwarding
    acc0(1, 16'h0456, 8'h77, "R13");
    // R4 card window edges
    acc0(0, 16'hE03F, 8'h00, "R4");
    acc0(0, 16'hE040, 8'h00, "R4");
    acc0(1, 16'hE000, 8'h12, "R4");
    // R5 peripheral window
    acc0(0, 16'hF000, 8'h00, "R5");
    acc0(1, 16'hF7FF, 8'h44, "R5");
    acc0(0, 16'hFFFF, 8'h00, "R5");
    // map 5, I/O holes closed
    set_mi(0, 8'h85);
    acc0(0, 16'hF800, 8'h00, "R5");
    acc0(0, 16'hE000, 8'h00, "R4");
    acc0(0, 16'h9000, 8'h00, "R3");
    acc0(0, 16'h3800, 8'h00, "R9");
    // R9 reload of that entry, data bit 7 ignored
    load_raw(8'h80, {5'd5, 5'd7}, 8'hFF);
    acc0(0, 16'h3801, 8'h00, "R9");
    load_raw(8'h80, {5'd5, 5'd0}, 8'h05);
    acc0(0, 16'h0002, 8'h00, "R9");

    // R6 overlay
    set_ovl(4'h5);
    step(1, 0, 16'h4567, 8'h00, 1, 0, 16'h4567, 8'h00, "R6");
    set_ovl(4'h4);
    acc0(0, 16'h0100, 8'h00, "R6");
    set_ovl(4'h1);
    acc0(0, 16'h4567, 8'h00, "R6");
    set_ovl(4'h7);
    step(1, 0, 16'hC100, 8'h00, 1, 0, 16'hF000, 8'h00, "R6");
    step(1, 1, 16'hF000, 8'h5C, 1, 0, 16'hE010, 8'h00, "R6");
    step(1, 0, 16'hE800, 8'h00, 1, 0, 16'hE800, 8'h00, "R6");
    set_ovl(4'h6);
    step(1, 0, 16'h8100, 8'h00, 1, 0, 16'h8100, 8'h00, "R6");
    // R7 mask for processor 1
    set_ovl(4'hD);
    step(1, 0, 16'h4567, 8'h00, 1, 0, 16'h4567, 8'h00, "R7");
    step(1, 1, 16'h7FFF, 8'hA1, 1, 1, 16'h7FFF, 8'hA2, "R7");

    // R8 parity mode
    set_ovl(4'h0);
    set_mi(0, 8'h40);
    acc0(0, 16'h0800, 8'h00, "R8");
    acc0(1, 16'h0800, 8'h3E, "R8");
    acc0(0, 16'hC800, 8'h00, "R8");
    acc0(0, 16'h9000, 8'h00, "R8");
    acc0(0, 16'hE800, 8'h00, "R8");
    acc0(0, 16'h1800, 8'h00, "R8");
    set_ovl(4'h5);
    acc0(0, 16'h4100, 8'h00, "R8");
    acc0(0, 16'h0100, 8'h00, "R8");

    // R11 idle cycles between and after traffic
    step(0, 0, 16'h0000, 8'h00, 0, 0, 16'h0000, 8'h00, "R11");
    step(0, 1, 16'h1234, 8'h11, 0, 1, 16'hF000, 8'h22, "R11");

    // back-to-back mixed traffic, R12
    for (int k = 0; k < 24; k++) begin
      step(1, k[0], 16'(16'h1357 * k + 16'h0101), 8'(k),
           (k % 3) != 0, k[1], 16'(16'h2468 * k + 16'h0F0F), 8'(8'hF0 - k), "R12");
    end
    set_mi(0, 8'hE2);
    for (int k = 0; k < 12; k++)
      step(1, 0, 16'(16'h1555 * k), 8'h00, 1, 1, 16'(16'hFFFF - 16'h1111 * k), 8'(k), "R12");

    step(0, 0, 16'h0, 8'h0, 0, 0, 16'h0, 8'h0, "R11");
    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule